// File: doc/BRIEF.md
# Expansion-Card Bus-Master Transfer Sequencer

This block lets an expansion card take over the shared 8-bit system bus and run a block of memory transfers at the slow bus rate, one transfer for each PH0 period. It is clocked by a fast card clock (the 7M clock or faster) and watches the PH0 input to find the edges of each bus cycle. A one-cycle start command supplies a bank value, a 16-bit base address, a transfer count and a direction. The sequencer then claims the bus. It first writes the bank value to the bank register, which is a normal write cycle to a fixed I/O address. It then walks through the address block. Each byte is either captured from the bus into the card's buffer (memory read) or sourced from that buffer onto the bus (memory write).

The takeover line is active low and open drain. The block reports it as a drive enable plus a drive level, so that pad logic outside the block can build the three-state pin. Every change on that line happens within a fixed number of fast-clock ticks after a PH0 falling edge. The address is enabled a fixed number of ticks after takeover. On release the line is first driven high for a few ticks and only then floated, because the system pull-up is weak.

The controller has these states: ST_IDLE, ST_WAIT_FALL, ST_ASSERT, ST_ADDR_DRIVE, ST_BANK_WR, ST_XFER, ST_RELEASE and ST_DONE. Its transitions are:
- ST_IDLE to ST_WAIT_FALL on an accepted start.
- ST_WAIT_FALL to ST_ASSERT on a PH0 fall.
- ST_ASSERT to ST_ADDR_DRIVE after ADDR_DELAY_TICKS ticks.
- ST_ADDR_DRIVE to ST_BANK_WR on a PH0 rise while the bank write is still pending, otherwise to ST_XFER.
- ST_BANK_WR to ST_ADDR_DRIVE on a PH0 fall.
- ST_XFER to ST_ADDR_DRIVE on a PH0 fall, or to ST_RELEASE on a PH0 fall when the transfer is the last one.
- ST_RELEASE to ST_DONE after RELEASE_TICKS ticks.
- ST_DONE to ST_IDLE unconditionally.

PH0 is taken to be synchronous to `clk`, or already synchronised to it.

Top module: `busmaster_dma_seq`

## Requirements
- R1: After reset the block is idle: busy, done, dma_oe, addr_oe, dout_oe and buf_we are all 0.
- R2: A start is accepted only in ST_IDLE and only with a nonzero count. A start with count 0 leaves busy and dma_oe at 0. A start while busy does not change the running job's addresses, direction or data.
- R3: In the first clock cycle after the edge at which a PH0 fall is first seen following an accepted start, the takeover line is driven low (dma_oe=1, dma_lvl=0). Every change of {dma_oe, dma_lvl} occurs fewer than DMA_WINDOW_TICKS (default 12) ticks after a PH0 fall.
- R4: addr_oe rises exactly ADDR_DELAY_TICKS (default 4) cycles after the takeover line goes low, and never later than ADDR_LIMIT_TICKS (default 15) ticks after the PH0 fall.
- R5: The first bus cycle after takeover writes the bank value (rw=0) to BANK_REG_ADDR (default 16'hC037). No transfer address is driven before that write has finished.
- R6: After the bank write, exactly `count` transfers follow, one per PH0 period, at addresses base, base+1, … modulo 2^16. rw is 1 for a memory read (start_rd=1) and 0 for a memory write.
- R7: On a memory read, at the PH0 fall that ends transfer i, bus_din is written to the card buffer (buf_we for one cycle, buf_addr=i, buf_wdata=bus_din).
- R8: On a write cycle (the bank write, or transfers with start_rd=0), dout_oe is 1 only after a PH0 rise has been seen and drops at the PH0 fall. dout carries the bank value or buf_rdata for buf_addr=i. On memory reads dout_oe stays 0.
- R9: At the PH0 fall that ends the last transfer, addr_oe drops and the line is driven high (dma_oe=1, dma_lvl=1) for RELEASE_TICKS (default 2) cycles before dma_oe returns to 0.
- R10: busy is 1 from the cycle after an accepted start through ST_DONE. done is a one-cycle pulse in the cycle after the release drive ends, with dma_oe and addr_oe at 0.
- R11: The takeover line stays low across all transfers of a job, however long the job is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast card clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph0 | input | 1 | Slow bus clock, synchronous to clk |
| start | input | 1 | One-cycle start command |
| start_bank | input | 8 | Bank value written to the bank register |
| start_base | input | 16 | First transfer address |
| start_count | input | 16 | Number of transfers |
| start_rd | input | 1 | 1: memory read into buffer; 0: buffer to memory |
| bus_din | input | 8 | Bus read data |
| buf_rdata | input | 8 | Card buffer data at buf_addr |
| dma_oe | output | 1 | Drive enable of the takeover line |
| dma_lvl | output | 1 | Level driven on the takeover line when enabled |
| addr | output | 16 | Bus address |
| addr_oe | output | 1 | Address drive enable |
| rw | output | 1 | 1 read, 0 write |
| dout | output | 8 | Bus write data |
| dout_oe | output | 1 | Data drive enable |
| buf_addr | output | 16 | Card buffer index |
| buf_we | output | 1 | Card buffer write strobe |
| buf_wdata | output | 8 | Card buffer write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished, one-cycle pulse |

## Verification
A wrong state shows up within one bus cycle. A missed or extra PH0 edge moves the bank write or a transfer address into the wrong PH0 period, which the per-period address checks catch. A skipped bank phase puts the base address where 16'hC037 is expected. A wrong tick count moves addr_oe or the release drive off its expected cycle by at least one tick, and a counter error leaves one buffer entry too many or too few. Random jobs vary the base (including wrap), the count, the direction and the data. Directed cases cover a zero count, a start during a job and a long hold.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FALL,
        ST_ASSERT,
        ST_ADDR_DRIVE,
        ST_BANK_WR,
        ST_XFER,
        ST_RELEASE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/dma_ph0_edge.sv
module dma_ph0_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ph0,
    output logic ph0_q,
    output logic ph0_fall,
    output logic ph0_rise
);
    always_ff @(posedge clk) begin
        if (!rst_n) ph0_q <= 1'b0;
        else        ph0_q <= ph0;
    end

    assign ph0_fall = ph0_q & ~ph0;
    assign ph0_rise = ~ph0_q & ph0;
endmodule

// File: rtl/dma_tick_cnt.sv
module dma_tick_cnt #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [TW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] idx,
    output logic [AW-1:0] cur_addr,
    output logic          last
);
    logic [CW-1:0] remaining;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            remaining <= '0;
            idx       <= '0;
        end else if (load) begin
            base_q    <= base;
            remaining <= count;
            idx       <= '0;
        end else if (step) begin
            idx       <= idx + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign cur_addr = base_q + AW'(idx);
    assign last     = (remaining == CW'(1));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remaining != '0));
endmodule

// File: rtl/busmaster_dma_seq.sv
module busmaster_dma_seq
    import dma_seq_pkg::*;
#(
    parameter int          AW               = 16,
    parameter int          CW               = 16,
    parameter int          DW               = 8,
    parameter int          BW               = 8,
    parameter int          TW               = 5,
    parameter int          DMA_WINDOW_TICKS = 12,
    parameter int          ADDR_DELAY_TICKS = 4,
    parameter int          ADDR_LIMIT_TICKS = 15,
    parameter int          RELEASE_TICKS    = 2,
    parameter logic [15:0] BANK_REG_ADDR    = 16'hC037
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph0,
    input  logic          start,
    input  logic [BW-1:0] start_bank,
    input  logic [AW-1:0] start_base,
    input  logic [CW-1:0] start_count,
    input  logic          start_rd,
    input  logic [DW-1:0] bus_din,
    input  logic [DW-1:0] buf_rdata,
    output logic          dma_oe,
    output logic          dma_lvl,
    output logic [AW-1:0] addr,
    output logic          addr_oe,
    output logic          rw,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic [CW-1:0] buf_addr,
    output logic          buf_we,
    output logic [DW-1:0] buf_wdata,
    output logic          busy,
    output logic          done
);
    localparam logic [TW-1:0] ADDR_LAST_TICK = TW'(ADDR_DELAY_TICKS - 1);
    localparam logic [TW-1:0] REL_LAST_TICK  = TW'(RELEASE_TICKS - 1);
    localparam logic [TW-1:0] WINDOW_TICK    = TW'(DMA_WINDOW_TICKS);
    localparam logic [TW-1:0] ADDR_MIN_TICK  = TW'(ADDR_DELAY_TICKS);
    localparam logic [TW-1:0] ADDR_MAX_TICK  = TW'(ADDR_LIMIT_TICKS);

    seq_state_t state, next_state;

    logic          ph0_q, ph0_fall, ph0_rise;
    logic [TW-1:0] tick;
    logic          load, step, last;
    logic [CW-1:0] idx;
    logic [AW-1:0] cur_addr;
    logic [BW-1:0] bank_q;
    logic          rd_q;
    logic          bank_done;
    logic          bank_phase;

    dma_ph0_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph0      (ph0),
        .ph0_q    (ph0_q),
        .ph0_fall (ph0_fall),
        .ph0_rise (ph0_rise)
    );

    dma_tick_cnt #(.TW(TW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ph0_fall),
        .cnt   (tick)
    );

    dma_xfer_ctr #(.AW(AW), .CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .base     (start_base),
        .count    (start_count),
        .idx      (idx),
        .cur_addr (cur_addr),
        .last     (last)
    );

    assign load = (state == ST_IDLE) && start && (start_count != '0);
    assign step = (state == ST_XFER) && ph0_fall;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Job context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q    <= '0;
            rd_q      <= 1'b0;
            bank_done <= 1'b0;
        end else if (load) begin
            bank_q    <= start_bank;
            rd_q      <= start_rd;
            bank_done <= 1'b0;
        end else if ((state == ST_BANK_WR) && ph0_fall) begin
            bank_done <= 1'b1;
        end
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:       if (load) next_state = ST_WAIT_FALL;
            ST_WAIT_FALL:  if (ph0_fall) next_state = ST_ASSERT;
            ST_ASSERT:     if (tick == ADDR_LAST_TICK) next_state = ST_ADDR_DRIVE;
            ST_ADDR_DRIVE: if (ph0_rise) next_state = bank_done ? ST_XFER : ST_BANK_WR;
            ST_BANK_WR:    if (ph0_fall) next_state = ST_ADDR_DRIVE;
            ST_XFER:       if (ph0_fall) next_state = last ? ST_RELEASE : ST_ADDR_DRIVE;
            ST_RELEASE:    if (tick == REL_LAST_TICK) next_state = ST_DONE;
            ST_DONE:       next_state = ST_IDLE;
            default:       next_state = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        dma_oe     = 1'b0;
        dma_lvl    = 1'b1;
        addr_oe    = 1'b0;
        dout_oe    = 1'b0;
        buf_we     = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        bank_phase = 1'b0;
        unique case (state)
            ST_IDLE:       busy = 1'b0;
            ST_WAIT_FALL:  ;
            ST_ASSERT: begin
                dma_oe  = 1'b1;
                dma_lvl = 1'b0;
            end
            ST_ADDR_DRIVE: begin
                dma_oe     = 1'b1;
                dma_lvl    = 1'b0;
                addr_oe    = 1'b1;
                bank_phase = !bank_done;
            end
            ST_BANK_WR: begin
                dma_oe     = 1'b1;
                dma_lvl    = 1'b0;
                addr_oe    = 1'b1;
                bank_phase = 1'b1;
                dout_oe    = ph0_q;
            end
            ST_XFER: begin
                dma_oe  = 1'b1;
                dma_lvl = 1'b0;
                addr_oe = 1'b1;
                dout_oe = ph0_q && !rd_q;
                buf_we  = rd_q && ph0_fall;
            end
            ST_RELEASE:    dma_oe = 1'b1;
            ST_DONE:       done = 1'b1;
            default:       busy = 1'b0;
        endcase
    end

    assign addr      = bank_phase ? AW'(BANK_REG_ADDR) : cur_addr;
    assign rw        = bank_phase ? 1'b0 : rd_q;
    assign dout      = (state == ST_BANK_WR) ? DW'(bank_q) : buf_rdata;
    assign buf_addr  = idx;
    assign buf_wdata = bus_din;

    // R3
    dma_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({dma_oe, dma_lvl}) |-> (tick < WINDOW_TICK));
    // R4
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> (tick >= ADDR_MIN_TICK) && (tick <= ADDR_MAX_TICK));
    // R5
    bank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && (addr != AW'(BANK_REG_ADDR))) |-> bank_done);
    // R8
    dout_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (addr_oe && dma_oe && !dma_lvl));
    // R9
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_oe) |-> $past(dma_lvl));
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dma_oe && !addr_oe));
endmodule

// File: tb/tb_busmaster_dma_seq.sv
module tb_busmaster_dma_seq;
    localparam int PH0_PER    = 125;
    localparam int PH0_LOW    = 62;
    localparam int ADDR_DELAY = 4;
    localparam int RELEASE    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        ph0 = 1'b0, ph0_fell = 1'b0, ph0_rose = 1'b0;
    int unsigned phc = 0;
    always @(negedge clk) begin
        int unsigned n;
        n = (phc + 1) % PH0_PER;
        phc      <= n;
        ph0      <= (n >= PH0_LOW);
        ph0_fell <= (n == 0);
        ph0_rose <= (n == PH0_LOW);
    end

    logic        start = 1'b0, start_rd = 1'b0;
    logic [7:0]  start_bank = '0, bus_din = '0;
    logic [15:0] start_base = '0, start_count = '0;
    logic [7:0]  buf_rdata, dout, buf_wdata;
    logic        dma_oe, dma_lvl, addr_oe, rw, dout_oe, buf_we, busy, done;
    logic [15:0] addr, buf_addr;
    logic [7:0]  mem [64];

    function automatic logic [7:0] fbuf(input logic [15:0] i);
        return (i[7:0] * 8'd13) ^ 8'h5A;
    endfunction

    assign buf_rdata = fbuf(buf_addr);
    always @(posedge clk) if (buf_we) mem[buf_addr[5:0]] <= buf_wdata;

    busmaster_dma_seq dut (
        .clk(clk), .rst_n(rst_n), .ph0(ph0), .start(start),
        .start_bank(start_bank), .start_base(start_base), .start_count(start_count),
        .start_rd(start_rd), .bus_din(bus_din), .buf_rdata(buf_rdata),
        .dma_oe(dma_oe), .dma_lvl(dma_lvl), .addr(addr), .addr_oe(addr_oe), .rw(rw),
        .dout(dout), .dout_oe(dout_oe), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .busy(busy), .done(done)
    );

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_fall();
        do step(); while (!ph0_fell);
    endtask

    task automatic wait_rise();
        do step(); while (!ph0_rose);
    endtask

    task automatic run_job(input logic [7:0] bank, input logic [15:0] base,
                           input int cnt, input bit rd, input bit poke);
        logic [7:0]  exp_rd [64];
        logic [15:0] ea;
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 8'h00;
            exp_rd[i] = 8'h00;
        end
        wait_rise();
        repeat (3) step();
        start = 1; start_bank = bank; start_base = base;
        start_count = 16'(cnt); start_rd = rd;
        step();
        start = 0;
        chk(busy == 1, "R10", "busy after start", busy, 1);
        wait_fall();
        if (poke) begin // R2: start while busy must be ignored
            start = 1; start_count = 16'd5; start_base = 16'h0100; start_rd = ~rd;
            start_bank = 8'h77;
        end
        step();
        start = 0;
        chk(dma_oe == 1 && dma_lvl == 0, "R3", "takeover after fall", {dma_oe, dma_lvl}, 2'b10);
        chk(addr_oe == 0, "R4", "addr off at takeover", addr_oe, 0);
        for (int k = 1; k < ADDR_DELAY; k++) begin
            step();
            chk(addr_oe == 0, "R4", "addr still off", addr_oe, 0);
        end
        step();
        chk(addr_oe == 1, "R4", "addr on after delay", addr_oe, 1);
        chk(addr == 16'hC037 && rw == 0, "R5", "bank reg address", {addr, rw}, {16'hC037, 1'b0});
        wait_rise();
        repeat (10) step();
        chk(dout_oe == 1 && dout == bank, "R5", "bank write data", {dout_oe, dout}, {1'b1, bank});
        for (int i = 0; i < cnt; i++) begin
            ea = base + 16'(i);
            wait_fall();
            step();
            chk(addr_oe == 1 && addr == ea, "R6", "transfer address", addr, ea);
            chk(rw == rd, "R6", "direction", rw, rd);
            chk(dout_oe == 0, "R8", "data off in low phase", dout_oe, 0);
            chk(dma_oe == 1 && dma_lvl == 0, "R11", "line held low", {dma_oe, dma_lvl}, 2'b10);
            wait_rise();
            exp_rd[i] = 8'($urandom);
            bus_din   = exp_rd[i];
            repeat (10) step();
            chk(dout_oe == !rd, "R8", "data enable in high phase", dout_oe, !rd);
            if (!rd) chk(dout == fbuf(16'(i)), "R8", "write data", dout, fbuf(16'(i)));
        end
        wait_fall();
        step();
        chk(dma_oe == 1 && dma_lvl == 1 && addr_oe == 0, "R9", "release drive",
            {dma_oe, dma_lvl, addr_oe}, 3'b110);
        for (int k = 1; k < RELEASE; k++) begin
            step();
            chk(dma_oe == 1 && dma_lvl == 1, "R9", "release still driven", {dma_oe, dma_lvl}, 2'b11);
        end
        step();
        chk(dma_oe == 0, "R9", "line floated", dma_oe, 0);
        chk(done == 1 && busy == 1, "R10", "done pulse", {done, busy}, 2'b11);
        step();
        chk(done == 0 && busy == 0, "R10", "back to idle", {done, busy}, 2'b00);
        if (rd) begin
            for (int i = 0; i < cnt; i++)
                chk(mem[i] == exp_rd[i], "R7", "captured byte", mem[i], exp_rd[i]);
            chk(mem[cnt] == 8'h00, "R7", "no extra capture", mem[cnt], 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20250));
        repeat (5) step();
        rst_n = 1;
        step();
        // R1
        chk(busy == 0 && done == 0, "R1", "status after reset", {busy, done}, 0);
        chk(dma_oe == 0 && addr_oe == 0 && dout_oe == 0 && buf_we == 0, "R1", "drivers after reset",
            {dma_oe, addr_oe, dout_oe, buf_we}, 0);

        run_job(8'hE1, 16'h2000, 3, 1'b0, 1'b0);
        run_job(8'h01, 16'hFFFE, 4, 1'b1, 1'b1);

        // R2: zero count ignored
        wait_rise();
        start = 1; start_count = 16'd0; start_base = 16'h1234; start_rd = 1;
        step();
        start = 0;
        repeat (300) step();
        chk(busy == 0 && dma_oe == 0, "R2", "zero count ignored", {busy, dma_oe}, 0);

        run_job(8'h00, 16'h0400, 40, 1'b0, 1'b1); // R11 long hold

        for (int j = 0; j < 6; j++)
            run_job(8'($urandom), 16'($urandom), 1 + int'($urandom % 20), 1'($urandom), 1'($urandom));

        summary();
    end
endmodule